// File: doc/BRIEF.md
# Programmable Burst Pulse Generator

This block turns a handful of timing settings into a gated train of pulses on one clock. After a restart the output waits for a lead-in interval, then emits pulses of a set width, separated by a set gap, until a pulse limit is met. At the limit it either halts with its limit flag raised, or starts the whole sequence again and raises the flag for one cycle. The finished waveform can be shifted later by a set number of cycles.

Two selectors route one of several source lines to the block. The first source line acts as the run enable. While it is low the sequence is frozen and nothing new is emitted. The second source line, together with a dedicated pull-down input, blanks the output while the sequence keeps running. Several copies can therefore gate one another to build nested waveforms: a long gate, a shutter inside it and a trigger train inside that. The limit flag of one copy can be wired to the enable or blanking source of another.

The sequencer has four named states:
- LEAD is the lead-in interval.
- HIGH is one pulse.
- GAP is the interval between pulses.
- HALT is the stopped state.

Its transitions are:
- LEAD→HIGH when the lead-in ends.
- HIGH→GAP when a pulse ends below the limit with a non-zero gap.
- HIGH→HIGH when the gap is zero.
- GAP→HIGH when the gap ends.
- HIGH→HALT when the limit is met with repeat off.
- HIGH→LEAD (or HIGH→HIGH when the lead-in is zero) when the limit is met with repeat on. This is the wrap.
- Any state goes to the entry state on reset or on a configuration load.

Top module: `burst_pulser`

## Requirements
- R1: A synchronous reset (`rst`) or a configuration load (`cfg_load`) puts the sequencer in its entry state on the next cycle. The entry state is LEAD, or HIGH when `t_lead` is 0. The restart clears all counters and the delay history, so `pulse_out` and `max_flag` read 0 whenever the entry state is LEAD.
- R2: After a restart the output stays low for exactly `t_lead` cycles before the first high cycle.
- R3: Each pulse is high for `t_len` cycles. A value of 0 is treated as 1.
- R4: Consecutive pulses are separated by `t_gap` low cycles. A gap of 0 joins pulses into one continuous high level.
- R5: After pulse number `max_pulses` with `repeat_en` low, the sequencer enters HALT. In HALT the output stays low and `max_flag` stays high until the next reset or load. A `max_pulses` of 0 means no limit.
- R6: With `repeat_en` high, meeting the limit restarts the sequence from the entry state with the pulse count cleared. `max_flag` is then high for exactly one cycle.
- R7: `pulse_out` is the gated sequence delayed by `t_delay` cycles. Delays above `DLY_DEPTH` (32 by default) act as `DLY_DEPTH`.
- R8: The enable selector works as follows:
  - `en_sel` = 0 means always enabled.
  - `en_sel` = k, with 1 ≤ k ≤ `NSRC`, selects `en_src[k-1]`.
  - Any other value means always enabled.
  While the selected enable is low, the state and counters do not change and the undelayed sequence is low.
- R9: The force selector works as follows:
  - `frc_sel` = 0 selects no source.
  - `frc_sel` = k, with 1 ≤ k ≤ `NSRC`, selects `frc_src[k-1]`.
  - Any other value selects no source.
  The selected source, or `force_pd`, drives `pulse_out` to 0 in the same cycle, after the delay stage. The counters keep running, so the pulse limit is still reached.
- R10: With `t_len` = 1, `t_gap` = 0 and a limit of N, the block gives exactly N high cycles and then halts.
- R11: `max_flag` is not delayed. It rises in the cycle after the last high cycle of the pulse that meets the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | One-cycle pulse: new settings are valid, restart the sequence |
| t_lead | input | CW (16) | Lead-in cycles after a restart |
| t_len | input | CW (16) | Pulse width in cycles |
| t_gap | input | CW (16) | Low cycles between pulses |
| max_pulses | input | PCW (32) | Pulse limit, 0 = unlimited |
| t_delay | input | CW (16) | Output delay in cycles |
| repeat_en | input | 1 | Restart after the limit instead of halting |
| en_sel | input | SELW (8) | Enable source select |
| frc_sel | input | SELW (8) | Force-low source select |
| en_src | input | NSRC (4) | Candidate enable lines |
| frc_src | input | NSRC (4) | Candidate force-low lines |
| force_pd | input | 1 | Direct pull-down of the output |
| pulse_out | output | 1 | Delayed, gated pulse train |
| max_flag | output | 1 | Limit reached (held in HALT, one cycle on wrap) |

## Verification
The most delicate overlap is blanking arriving in the same cycle as the pulse that meets the limit. In that cycle the output must read 0, while `max_flag` must still rise and the sequencer must still halt or wrap. A second overlap is the enable dropping in that same last cycle, which must postpone the limit. Both are provoked by directed runs that hold the force or enable lines across whole bursts. They are also provoked by random runs that toggle every source line each cycle against short settings. In every run, a behavioural model in the bench predicts `pulse_out` and `max_flag` for each cycle and judges them, and directed counts of high cycles and first-high positions give a second, independent check.

// File: rtl/burst_pulser_pkg.sv
package burst_pulser_pkg;

    typedef enum logic [1:0] {
        ST_LEAD = 2'd0,
        ST_HIGH = 2'd1,
        ST_GAP  = 2'd2,
        ST_HALT = 2'd3
    } bp_state_e;

endpackage

// File: rtl/burst_src_mux.sv
module burst_src_mux #(
    parameter int NSRC = 4,
    parameter int SELW = 8,
    parameter bit DFLT = 1'b0
) (
    input  logic [NSRC-1:0] src,
    input  logic [SELW-1:0] sel,
    output logic            y
);

    // Selector 0 and any out-of-range value give the default level.
    always_comb begin
        y = DFLT;
        for (int k = 0; k < NSRC; k++) begin
            if (sel == SELW'(k + 1)) begin
                y = src[k];
            end
        end
    end

endmodule

// File: rtl/burst_delay_line.sv
module burst_delay_line #(
    parameter int DEPTH = 32,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          clear,
    input  logic          din,
    input  logic [DW-1:0] dly,
    output logic          dout
);

    logic [DEPTH-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (clear) begin
            hist_q <= '0;
        end else begin
            hist_q <= {hist_q[DEPTH-2:0], din};
        end
    end

    // Tap k holds the input from k cycles ago; larger requests saturate.
    always_comb begin
        dout = din;
        for (int k = 1; k <= DEPTH; k++) begin
            if ((dly == DW'(k)) || ((k == DEPTH) && (dly > DW'(DEPTH)))) begin
                dout = hist_q[k-1];
            end
        end
    end

endmodule

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import burst_pulser_pkg::*;
#(
    parameter int CW  = 16,
    parameter int PCW = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           restart,
    input  logic           en,
    input  logic [CW-1:0]  t_lead,
    input  logic [CW-1:0]  t_len,
    input  logic [CW-1:0]  t_gap,
    input  logic [PCW-1:0] max_pulses,
    input  logic           repeat_en,
    output bp_state_e      state,
    output logic [CW-1:0]  cnt,
    output logic           raw,
    output logic           wrap
);

    bp_state_e      state_q, state_d, entry_st;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic [PCW-1:0] pcnt_q, pcnt_d;
    logic           wrap_q, wrap_d;
    logic [CW:0]    cnt_inc;
    logic [CW-1:0]  len_eff;
    logic [PCW:0]   pcnt_inc;
    logic           limit_hit;

    assign entry_st  = (t_lead == '0) ? ST_HIGH : ST_LEAD;
    assign len_eff   = (t_len == '0) ? CW'(1) : t_len;
    assign cnt_inc   = {1'b0, cnt_q} + 1'b1;
    assign pcnt_inc  = {1'b0, pcnt_q} + 1'b1;
    assign limit_hit = (max_pulses != '0) && (pcnt_inc == {1'b0, max_pulses});

    // State register process.
    always_ff @(posedge clk) begin
        if (rst || restart) begin
            state_q <= entry_st;
            cnt_q   <= '0;
            pcnt_q  <= '0;
            wrap_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pcnt_q  <= pcnt_d;
            wrap_q  <= wrap_d;
        end
    end

    // Transition process.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        pcnt_d  = pcnt_q;
        wrap_d  = 1'b0;
        if (en) begin
            unique case (state_q)
                ST_LEAD: begin
                    if (cnt_inc >= {1'b0, t_lead}) begin
                        state_d = ST_HIGH;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_inc[CW-1:0];
                    end
                end
                ST_HIGH: begin
                    if (cnt_inc >= {1'b0, len_eff}) begin
                        cnt_d = '0;
                        if (limit_hit) begin
                            pcnt_d = '0;
                            if (repeat_en) begin
                                state_d = entry_st;
                                wrap_d  = 1'b1;
                            end else begin
                                state_d = ST_HALT;
                            end
                        end else begin
                            pcnt_d  = pcnt_inc[PCW-1:0];
                            state_d = (t_gap == '0) ? ST_HIGH : ST_GAP;
                        end
                    end else begin
                        cnt_d = cnt_inc[CW-1:0];
                    end
                end
                ST_GAP: begin
                    if (cnt_inc >= {1'b0, t_gap}) begin
                        state_d = ST_HIGH;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_inc[CW-1:0];
                    end
                end
                ST_HALT: begin
                    state_d = ST_HALT;
                end
            endcase
        end
    end

    // Output process.
    always_comb begin
        state = state_q;
        cnt   = cnt_q;
        raw   = (state_q == ST_HIGH) && en;
        wrap  = wrap_q;
    end

endmodule

// File: rtl/burst_pulser.sv
module burst_pulser
    import burst_pulser_pkg::*;
#(
    parameter int NSRC      = 4,
    parameter int SELW      = 8,
    parameter int CW        = 16,
    parameter int PCW       = 32,
    parameter int DLY_DEPTH = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_load,
    input  logic [CW-1:0]   t_lead,
    input  logic [CW-1:0]   t_len,
    input  logic [CW-1:0]   t_gap,
    input  logic [PCW-1:0]  max_pulses,
    input  logic [CW-1:0]   t_delay,
    input  logic            repeat_en,
    input  logic [SELW-1:0] en_sel,
    input  logic [SELW-1:0] frc_sel,
    input  logic [NSRC-1:0] en_src,
    input  logic [NSRC-1:0] frc_src,
    input  logic            force_pd,
    output logic            pulse_out,
    output logic            max_flag
);

    logic          en_now;
    logic          frc_now;
    logic          seq_raw;
    logic          seq_wrap;
    logic          dly_out;
    bp_state_e     seq_state;
    logic [CW-1:0] seq_cnt;

    burst_src_mux #(.NSRC(NSRC), .SELW(SELW), .DFLT(1'b1)) u_en_mux (
        .src (en_src),
        .sel (en_sel),
        .y   (en_now)
    );

    burst_src_mux #(.NSRC(NSRC), .SELW(SELW), .DFLT(1'b0)) u_frc_mux (
        .src (frc_src),
        .sel (frc_sel),
        .y   (frc_now)
    );

    burst_seq_fsm #(.CW(CW), .PCW(PCW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .restart    (cfg_load),
        .en         (en_now),
        .t_lead     (t_lead),
        .t_len      (t_len),
        .t_gap      (t_gap),
        .max_pulses (max_pulses),
        .repeat_en  (repeat_en),
        .state      (seq_state),
        .cnt        (seq_cnt),
        .raw        (seq_raw),
        .wrap       (seq_wrap)
    );

    burst_delay_line #(.DEPTH(DLY_DEPTH), .DW(CW)) u_dly (
        .clk   (clk),
        .clear (rst || cfg_load),
        .din   (seq_raw),
        .dly   (t_delay),
        .dout  (dly_out)
    );

    // Blanking acts after the delay; the limit flag is not delayed.
    always_comb begin
        pulse_out = dly_out && !(force_pd || frc_now);
        max_flag  = (seq_state == ST_HALT) || seq_wrap;
    end

endmodule

// File: rtl/burst_pulser_chk.sv
module burst_pulser_chk
    import burst_pulser_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_load,
    input logic          force_pd,
    input logic          frc_now,
    input logic          en_now,
    input logic          pulse_out,
    input logic          max_flag,
    input logic [CW-1:0] t_len,
    input bp_state_e     state,
    input logic [CW-1:0] cnt
);

    logic [CW:0] len_eff;
    assign len_eff = (t_len == '0) ? (CW+1)'(1) : {1'b0, t_len};

    // R9: any blanking source zeroes the output in the same cycle
    a_r9_force_zero: assert property (@(posedge clk) disable iff (rst)
        (force_pd || frc_now) |-> !pulse_out);

    // R5: HALT is left only through reset or a load, and keeps the flag up
    a_r5_halt_holds: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT && !cfg_load) |=> (state == ST_HALT && max_flag));

    // R8: a low enable freezes the sequencer
    a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
        (!en_now && !cfg_load) |=> ($stable(state) && $stable(cnt)));

    // R3: the pulse-width counter never passes the programmed width
    a_r3_len_bound: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HIGH && $stable(t_len)) |-> ({1'b0, cnt} < len_eff));

    // R11: the limit flag only rises right after a high cycle
    a_r11_flag_after_high: assert property (@(posedge clk) disable iff (rst)
        $rose(max_flag) |-> ($past(state) == ST_HIGH));

endmodule

bind burst_pulser burst_pulser_chk #(.CW(CW)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_load  (cfg_load),
    .force_pd  (force_pd),
    .frc_now   (frc_now),
    .en_now    (en_now),
    .pulse_out (pulse_out),
    .max_flag  (max_flag),
    .t_len     (t_len),
    .state     (seq_state),
    .cnt       (seq_cnt)
);

// File: tb/test_burst_pulser.sv
module test_burst_pulser;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC  = 4;
    localparam int DEPTH = 32;

    logic        clk;
    logic        rst;
    logic        cfg_load;
    logic [15:0] t_lead, t_len, t_gap, t_delay;
    logic [31:0] max_pulses;
    logic        repeat_en;
    logic [7:0]  en_sel, frc_sel;
    logic [3:0]  en_src, frc_src;
    logic        force_pd;
    logic        pulse_out, max_flag;

    burst_pulser i_burst_pulser (
        .clk(clk), .rst(rst), .cfg_load(cfg_load),
        .t_lead(t_lead), .t_len(t_len), .t_gap(t_gap),
        .max_pulses(max_pulses), .t_delay(t_delay), .repeat_en(repeat_en),
        .en_sel(en_sel), .frc_sel(frc_sel), .en_src(en_src), .frc_src(frc_src),
        .force_pd(force_pd), .pulse_out(pulse_out), .max_flag(max_flag)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model: 0 lead-in, 1 high, 2 gap, 3 halted
    int      ms = 0;
    int      mc = 0;
    longint  mp = 0;
    bit      mwrap = 0;
    bit      mvalid = 0;
    bit      hist[$];

    // Directed observations since the last restart
    int  ncyc, nhigh, first_hi, nmax;
    bit  prev_max;

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_int(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit pick(logic [7:0] sel, logic [3:0] src, bit dflt);
        if (sel >= 8'd1 && sel <= 8'(NSRC)) return src[sel-1];
        return dflt;
    endfunction

    function automatic void obs_clear();
        ncyc = 0; nhigh = 0; first_hi = -1; nmax = 0; prev_max = 0;
    endfunction

    // One clock cycle: compare against the model, then advance the model.
    task automatic step(string req);
        bit m_en, m_frc, m_raw, dly_v, e_out, e_max;
        int d, lenf;
        #1;
        m_en  = pick(en_sel, en_src, 1'b1);
        m_frc = force_pd | pick(frc_sel, frc_src, 1'b0);
        m_raw = (ms == 1) && m_en;
        d = (t_delay > DEPTH) ? DEPTH : int'(t_delay);
        if (d == 0) dly_v = m_raw;
        else if (hist.size() >= d) dly_v = hist[hist.size() - d];
        else dly_v = 1'b0;
        e_out = dly_v && !m_frc;
        e_max = (ms == 3) || mwrap;
        if (mvalid) begin
            check({req, " out"}, pulse_out, e_out);
            check({req, " max_flag"}, max_flag, e_max);
        end
        if (!rst && !cfg_load) begin
            if (pulse_out === 1'b1) begin
                nhigh++;
                if (first_hi < 0) first_hi = ncyc;
            end
            if (max_flag === 1'b1 && !prev_max) nmax++;
            prev_max = (max_flag === 1'b1);
            ncyc++;
        end
        if (rst || cfg_load) begin
            ms = (t_lead == 0) ? 1 : 0;
            mc = 0; mp = 0; mwrap = 0; mvalid = 1;
            hist.delete();
        end else begin
            hist.push_back(m_raw);
            if (hist.size() > 40) void'(hist.pop_front());
            mwrap = 0;
            lenf = (t_len == 0) ? 1 : int'(t_len);
            if (m_en) begin
                case (ms)
                    0: if (mc + 1 >= t_lead) begin ms = 1; mc = 0; end else mc++;
                    1: if (mc + 1 >= lenf) begin
                           mc = 0;
                           if (max_pulses != 0 && mp + 1 == longint'(max_pulses)) begin
                               mp = 0;
                               if (repeat_en) begin
                                   ms = (t_lead == 0) ? 1 : 0;
                                   mwrap = 1;
                               end else ms = 3;
                           end else begin
                               mp++;
                               ms = (t_gap == 0) ? 1 : 2;
                           end
                       end else mc++;
                    2: if (mc + 1 >= t_gap) begin ms = 1; mc = 0; end else mc++;
                    default: ;
                endcase
            end
        end
        @(negedge clk);
    endtask

    task automatic load(int lead, int len, int gap, longint maxp, int dly, bit rep, string req);
        t_lead = 16'(lead); t_len = 16'(len); t_gap = 16'(gap);
        max_pulses = 32'(maxp); t_delay = 16'(dly); repeat_en = rep;
        cfg_load = 1'b1;
        step(req);
        cfg_load = 1'b0;
        obs_clear();
    endtask

    task automatic run(int n, string req);
        for (int i = 0; i < n; i++) step(req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1; cfg_load = 0; force_pd = 0;
        t_lead = 5; t_len = 3; t_gap = 2; max_pulses = 3; t_delay = 0;
        repeat_en = 0; en_sel = 0; frc_sel = 0; en_src = 0; frc_src = 0;
        @(negedge clk);
        step("R1 reset");
        step("R1 reset");
        check("R1 reset out", pulse_out, 1'b0);
        check("R1 reset max_flag", max_flag, 1'b0);
        rst = 0;
        obs_clear();

        // R2 R3 R4 R5: lead 5, width 3, gap 2, limit 3, no repeat
        run(40, "R2 R3 R4 R5");
        check_int("R2 first high index", first_hi, 5);
        check_int("R3 R4 high cycles", nhigh, 9);
        check("R5 halted flag", max_flag, 1'b1);
        check("R5 halted out", pulse_out, 1'b0);

        // R10: single-cycle trigger train of 6
        load(0, 1, 0, 6, 0, 0, "R10");
        run(20, "R10");
        check_int("R10 first high", first_hi, 0);
        check_int("R10 high cycles", nhigh, 6);

        // R6: repeat, period 7
        load(2, 2, 1, 2, 0, 1, "R6");
        run(35, "R6 R11");
        check_int("R6 wraps", nmax, 4);
        check_int("R6 high cycles", nhigh, 20);

        // R7: delay 4, then saturating delay
        load(1, 2, 3, 0, 4, 0, "R7");
        run(30, "R7");
        check_int("R7 delay 4 first high", first_hi, 5);
        load(1, 2, 3, 0, 100, 0, "R7 clamp");
        run(40, "R7 clamp");
        check_int("R7 clamped first high", first_hi, 33);

        // R8: enable held low, then out-of-range select
        en_sel = 2; en_src = 4'b0000;
        load(0, 1, 0, 3, 0, 0, "R8");
        run(15, "R8");
        check_int("R8 frozen high cycles", nhigh, 0);
        check("R8 frozen no flag", max_flag, 1'b0);
        en_src = 4'b0010;
        run(10, "R8 released");
        check_int("R8 released high cycles", nhigh, 3);
        en_sel = 200; en_src = 4'b0000;
        load(0, 1, 0, 3, 0, 0, "R8 range");
        run(10, "R8 range");
        check_int("R8 out-of-range high cycles", nhigh, 3);
        en_sel = 0;

        // R9: pull-down and selected force keep counting
        force_pd = 1;
        load(0, 2, 0, 4, 0, 0, "R9 pd");
        run(15, "R9 pd");
        check_int("R9 pd high cycles", nhigh, 0);
        check("R9 pd limit still reached", max_flag, 1'b1);
        force_pd = 0;
        frc_sel = 3; frc_src = 4'b0100;
        load(0, 2, 0, 4, 0, 0, "R9 sel");
        run(15, "R9 sel");
        check_int("R9 sel high cycles", nhigh, 0);
        check("R9 sel limit reached", max_flag, 1'b1);
        frc_sel = 9; frc_src = 4'b1111;
        load(0, 1, 0, 2, 0, 0, "R9 range");
        run(8, "R9 range");
        check_int("R9 out-of-range high cycles", nhigh, 2);
        frc_sel = 0; frc_src = 0;

        // R3: zero width acts as one
        load(0, 0, 1, 3, 0, 0, "R3 zero width");
        run(12, "R3 zero width");
        check_int("R3 zero width high cycles", nhigh, 3);

        // R1: mid-run reset restarts the lead-in
        load(3, 2, 2, 0, 0, 0, "R1");
        run(10, "R1");
        rst = 1;
        step("R1 mid reset");
        rst = 0;
        obs_clear();
        run(10, "R1 after reset");
        check_int("R1 restart first high", first_hi, 3);

        // Random overlap of enable, force, limit and wrap: R8 R9 R5 R6
        for (int r = 0; r < 20; r++) begin
            en_sel  = 8'($urandom_range(0, 5));
            frc_sel = 8'($urandom_range(0, 5));
            load($urandom_range(0, 4), $urandom_range(0, 3), $urandom_range(0, 3),
                 $urandom_range(0, 5), $urandom_range(0, 6), 1'($urandom_range(0, 1)),
                 "R8 R9 random");
            for (int c = 0; c < 150; c++) begin
                en_src   = 4'($urandom);
                frc_src  = 4'($urandom);
                force_pd = ($urandom_range(0, 9) == 0);
                step("R5 R6 R8 R9 random");
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule